// File: doc/BRIEF.md
# Delayed Transaction Tracker for One Bridge Direction

This block runs split-phase transfers for one direction of a bus-to-bus bridge. The first time an initiator presents a request, the block answers with a retry. It also keeps a copy of the request's address, command, byte enables and write data, and passes that copy to a simple request/response port on the destination side. The result that comes back is held in the block: a completion status, plus the data when the request was a read.

When the initiator tries again, the block compares the new request with the copy it kept. Only an exact match on address, command and byte enables, arriving after the destination side has finished, receives the stored result. That match also frees the single slot. Every other request gets another retry and leaves the slot as it was.

A configuration input chooses when retries are signalled. They can come at once, or a fixed number of clocks after the request begins.

Top module: `dly_txn_tracker`

## Requirements
- R1: After a synchronous reset, `rsp_retry`, `rsp_done`, `rsp_status`, `rsp_rdata` and `dst_req_valid` are all 0, and the slot is empty.
- R2: A request that finds the slot empty is answered with a retry and captured. In the following cycle, `dst_req_valid` rises and carries the captured address, command, byte enables and write data.
- R3: `dst_req_valid` stays high, with stable fields, until a cycle with `dst_req_ready` high. The block then accepts `dst_rsp_valid` only while it waits for a result.
- R4: A write is a command with bit 0 set to 1. For a write, the returned status is stored, and a matching retry receives it with `rsp_rdata` equal to 0.
- R5: A read is a command with bit 0 set to 0. For a read, the returned data and status are both stored and delivered on the matching retry.
- R6: While a result is held, a request that differs in address, command or byte enables gets a retry. It is not captured, and a later matching request still receives the original result.
- R7: A matching request that arrives before the destination side has returned a result gets a retry, and the slot keeps its transaction.
- R8: When `cfg_delay_retry` is 0, the response pulse (`rsp_retry` or `rsp_done`, never both) is visible in the first cycle after the first cycle in which the request is presented. The pulse lasts one cycle.
- R9: When `cfg_delay_retry` is 1, a retry appears 16 clocks (RETRY_DLY) after the request is first seen, counting edges, while a completion is still delivered at once.
- R10: Only one transaction is outstanding. No new destination request is issued until the held one has been delivered.
- R11: After a completion has been delivered, the slot is empty, and the next request is captured and forwarded.
- R12: A reset in the middle of a transaction discards it. The next request is captured anew and receives a retry, not a completion.
- R13: The status code is passed through unchanged: 00 normal, 01 target abort, 10 master abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_delay_retry | input | 1 | 1: retries are signalled after RETRY_DLY clocks; 0: at once |
| req_valid | input | 1 | Initiator request present; held until a response pulse is seen, then dropped for at least one cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command; bit 0 set to 1 means write |
| req_be | input | BE_W | Request byte enables |
| req_wdata | input | DATA_W | Write data |
| rsp_retry | output | 1 | One-cycle retry pulse to the initiator |
| rsp_done | output | 1 | One-cycle completion pulse to the initiator |
| rsp_status | output | 2 | Completion status, valid while `rsp_done` is high |
| rsp_rdata | output | DATA_W | Read data, valid while `rsp_done` is high (0 for writes) |
| dst_req_valid | output | 1 | Forwarded request valid |
| dst_req_ready | input | 1 | Destination accepts the forwarded request |
| dst_req_addr | output | ADDR_W | Forwarded address |
| dst_req_cmd | output | CMD_W | Forwarded command |
| dst_req_be | output | BE_W | Forwarded byte enables |
| dst_req_wdata | output | DATA_W | Forwarded write data |
| dst_rsp_valid | input | 1 | Destination result valid |
| dst_rsp_status | input | 2 | Destination completion status |
| dst_rsp_rdata | input | DATA_W | Destination read data |

## Verification
The main function is exercised with four kinds of retry:
- an exact repeat of the request before the result returns, which tells "slot busy" apart from "result ready";
- requests that differ only in address, only in byte enables or only in command, which shows that each field is compared on its own;
- an exact repeat after the result returns;
- a write followed by a read, which separates storing the status alone from storing status and data.

Each mode is also run with immediate and with delayed retry timing, which shows that the delay applies to retries and not to completions. A reset in mid-transaction checks that no stale result is ever delivered.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FWD   = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_st_t;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_WAIT = 2'd1,
    PORT_RESP = 2'd2,
    PORT_DROP = 2'd3
  } port_st_t;

  localparam logic [1:0] CPL_NORMAL = 2'b00;
  localparam logic [1:0] CPL_TABORT = 2'b01;
  localparam logic [1:0] CPL_MABORT = 2'b10;

  // counter preload so that the retry lands dly edges after the first sample
  function automatic int unsigned retry_load(input int unsigned dly);
    return dly - 1;
  endfunction

  function automatic logic cmd_is_write(input logic cmd_lsb);
    return cmd_lsb;
  endfunction

endpackage

// File: rtl/dtt_slot.sv
module dtt_slot
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              release_slot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              dst_req_ready,
  input  logic              dst_rsp_valid,
  input  logic [1:0]        dst_rsp_status,
  input  logic [DATA_W-1:0] dst_rsp_rdata,
  output logic              slot_empty,
  output logic              slot_hit,
  output logic              dst_req_valid,
  output logic [ADDR_W-1:0] dst_req_addr,
  output logic [CMD_W-1:0]  dst_req_cmd,
  output logic [BE_W-1:0]   dst_req_be,
  output logic [DATA_W-1:0] dst_req_wdata,
  output logic [1:0]        hold_status,
  output logic [DATA_W-1:0] hold_rdata
);

  function automatic logic fields_match(
    input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1,
    input logic [CMD_W-1:0]  c0, input logic [CMD_W-1:0]  c1,
    input logic [BE_W-1:0]   b0, input logic [BE_W-1:0]   b1);
    return (a0 == a1) && (c0 == c1) && (b0 == b1);
  endfunction

  slot_st_t st;

  assign slot_empty    = (st == SLOT_EMPTY);
  assign dst_req_valid = (st == SLOT_FWD);
  assign slot_hit      = (st == SLOT_DONE) &&
                         fields_match(req_addr, dst_req_addr, req_cmd, dst_req_cmd,
                                      req_be, dst_req_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= SLOT_EMPTY;
      dst_req_addr  <= '0;
      dst_req_cmd   <= '0;
      dst_req_be    <= '0;
      dst_req_wdata <= '0;
      hold_status   <= '0;
      hold_rdata    <= '0;
    end else begin
      case (st)
        SLOT_EMPTY: if (capture) begin
          st            <= SLOT_FWD;
          dst_req_addr  <= req_addr;
          dst_req_cmd   <= req_cmd;
          dst_req_be    <= req_be;
          dst_req_wdata <= req_wdata;
        end
        SLOT_FWD: if (dst_req_ready) st <= SLOT_WAIT;
        SLOT_WAIT: if (dst_rsp_valid) begin
          st          <= SLOT_DONE;
          hold_status <= dst_rsp_status;
          hold_rdata  <= cmd_is_write(dst_req_cmd[0]) ? '0 : dst_rsp_rdata;
        end
        default: if (release_slot) begin
          st            <= SLOT_EMPTY;
          dst_req_addr  <= '0;
          dst_req_cmd   <= '0;
          dst_req_be    <= '0;
          dst_req_wdata <= '0;
          hold_status   <= '0;
          hold_rdata    <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dtt_port.sv
module dtt_port
  import dtt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RETRY_DLY = 16,
  localparam int CNT_W    = $clog2(RETRY_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_delay_retry,
  input  logic              req_valid,
  input  logic              slot_empty,
  input  logic              slot_hit,
  input  logic [1:0]        hold_status,
  input  logic [DATA_W-1:0] hold_rdata,
  output logic              ev_sample,
  output logic              capture,
  output logic              release_slot,
  output logic              rsp_retry,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata
);

  port_st_t         pst;
  logic [CNT_W-1:0] cnt;

  assign ev_sample    = (pst == PORT_IDLE) && req_valid;
  assign capture      = ev_sample && slot_empty;
  assign release_slot = ev_sample && slot_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pst        <= PORT_IDLE;
      cnt        <= '0;
      rsp_retry  <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_status <= '0;
      rsp_rdata  <= '0;
    end else begin
      case (pst)
        PORT_IDLE: if (ev_sample) begin
          if (release_slot) begin
            rsp_done   <= 1'b1;
            rsp_status <= hold_status;
            rsp_rdata  <= hold_rdata;
            pst        <= PORT_RESP;
          end else if (cfg_delay_retry) begin
            cnt <= CNT_W'(retry_load(RETRY_DLY));
            pst <= PORT_WAIT;
          end else begin
            rsp_retry <= 1'b1;
            pst       <= PORT_RESP;
          end
        end
        PORT_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            rsp_retry <= 1'b1;
            cnt       <= '0;
            pst       <= PORT_RESP;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PORT_RESP: begin
          rsp_retry  <= 1'b0;
          rsp_done   <= 1'b0;
          rsp_status <= '0;
          rsp_rdata  <= '0;
          pst        <= PORT_DROP;
        end
        default: if (!req_valid) pst <= PORT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CMD_W     = 4,
  parameter int BE_W      = 4,
  parameter int RETRY_DLY = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_delay_retry,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_retry,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dst_req_valid,
  input  logic              dst_req_ready,
  output logic [ADDR_W-1:0] dst_req_addr,
  output logic [CMD_W-1:0]  dst_req_cmd,
  output logic [BE_W-1:0]   dst_req_be,
  output logic [DATA_W-1:0] dst_req_wdata,
  input  logic              dst_rsp_valid,
  input  logic [1:0]        dst_rsp_status,
  input  logic [DATA_W-1:0] dst_rsp_rdata
);

  logic              ev_sample;
  logic              capture;
  logic              release_slot;
  logic              slot_empty;
  logic              slot_hit;
  logic [1:0]        hold_status;
  logic [DATA_W-1:0] hold_rdata;

  dtt_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .BE_W(BE_W)) u_slot (
    .clk(clk), .rst(rst), .capture(capture), .release_slot(release_slot),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_wdata(req_wdata),
    .dst_req_ready(dst_req_ready), .dst_rsp_valid(dst_rsp_valid),
    .dst_rsp_status(dst_rsp_status), .dst_rsp_rdata(dst_rsp_rdata),
    .slot_empty(slot_empty), .slot_hit(slot_hit), .dst_req_valid(dst_req_valid),
    .dst_req_addr(dst_req_addr), .dst_req_cmd(dst_req_cmd), .dst_req_be(dst_req_be),
    .dst_req_wdata(dst_req_wdata), .hold_status(hold_status), .hold_rdata(hold_rdata)
  );

  dtt_port #(.DATA_W(DATA_W), .RETRY_DLY(RETRY_DLY)) u_port (
    .clk(clk), .rst(rst), .cfg_delay_retry(cfg_delay_retry), .req_valid(req_valid),
    .slot_empty(slot_empty), .slot_hit(slot_hit), .hold_status(hold_status),
    .hold_rdata(hold_rdata), .ev_sample(ev_sample), .capture(capture),
    .release_slot(release_slot), .rsp_retry(rsp_retry), .rsp_done(rsp_done),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_delay_retry,
  input logic              ev_sample,
  input logic              capture,
  input logic              slot_empty,
  input logic              rsp_retry,
  input logic              rsp_done,
  input logic              dst_req_valid,
  input logic              dst_req_ready,
  input logic [ADDR_W-1:0] dst_req_addr,
  input logic [BE_W-1:0]   dst_req_be
);

  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_retry && !rsp_done && !dst_req_valid));

  // R3: forwarded request held stable until accepted
  a_r3_fwd_hold: assert property (@(posedge clk) disable iff (rst)
    (dst_req_valid && !dst_req_ready) |=>
      (dst_req_valid && $stable(dst_req_addr) && $stable(dst_req_be)));

  // R8: retry and completion never together, each a single pulse
  a_r8_one_resp: assert property (@(posedge clk) disable iff (rst)
    !(rsp_retry && rsp_done));
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    (rsp_retry || rsp_done) |=> !(rsp_retry || rsp_done));

  // R8: in immediate mode a sampled request is answered next cycle
  a_r8_immediate: assert property (@(posedge clk) disable iff (rst)
    (ev_sample && !cfg_delay_retry) |=> (rsp_retry || rsp_done));

  // R9: in delayed mode a captured request is not answered next cycle
  a_r9_delayed: assert property (@(posedge clk) disable iff (rst)
    (capture && cfg_delay_retry) |=> !rsp_retry);

  // R10: a new forward only after a capture into an empty slot
  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    $rose(dst_req_valid) |-> ($past(capture) && $past(slot_empty)));

endmodule

bind dly_txn_tracker dtt_checker #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_delay_retry(cfg_delay_retry), .ev_sample(ev_sample),
  .capture(capture), .slot_empty(slot_empty), .rsp_retry(rsp_retry),
  .rsp_done(rsp_done), .dst_req_valid(dst_req_valid), .dst_req_ready(dst_req_ready),
  .dst_req_addr(dst_req_addr), .dst_req_be(dst_req_be)
);

// File: tb/sim_dly_txn_tracker.sv
`timescale 1ns/1ps
module sim_dly_txn_tracker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_delay_retry = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_retry, rsp_done;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        dst_req_valid;
  logic        dst_req_ready = 1'b0;
  logic [31:0] dst_req_addr, dst_req_wdata;
  logic [3:0]  dst_req_cmd, dst_req_be;
  logic        dst_rsp_valid = 1'b0;
  logic [1:0]  dst_rsp_status = '0;
  logic [31:0] dst_rsp_rdata = '0;

  always #10 clk = ~clk;

  dly_txn_tracker u0 (
    .clk(clk), .rst(rst), .cfg_delay_retry(cfg_delay_retry), .req_valid(req_valid),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .dst_req_valid(dst_req_valid), .dst_req_ready(dst_req_ready),
    .dst_req_addr(dst_req_addr), .dst_req_cmd(dst_req_cmd), .dst_req_be(dst_req_be),
    .dst_req_wdata(dst_req_wdata), .dst_rsp_valid(dst_rsp_valid),
    .dst_rsp_status(dst_rsp_status), .dst_rsp_rdata(dst_rsp_rdata)
  );

  integer n_checks = 0;
  integer n_fail   = 0;
  string  cur_tag  = "R1";
  bit     finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  integer      m_slot  = 0;   // 0 empty, 1 forwarding, 2 waiting, 3 holding
  integer      m_phase = 0;   // 0 idle, 1 counting, 2 pulse, 3 wait drop
  integer      m_cnt   = 0;
  logic [31:0] m_addr = '0, m_wd = '0, m_sdata = '0;
  logic [3:0]  m_cmd = '0, m_be = '0;
  logic [1:0]  m_sstat = '0;
  logic        e_retry = 0, e_done = 0;
  logic [1:0]  e_stat = '0;
  logic [31:0] e_rdata = '0;
  integer      fwd_count = 0;

  always @(posedge clk) begin
    bit take, give, hit;
    take = 0; give = 0;
    if (rst) begin
      m_slot = 0; m_phase = 0; m_cnt = 0;
      m_addr = 0; m_wd = 0; m_cmd = 0; m_be = 0; m_sstat = 0; m_sdata = 0;
      e_retry = 0; e_done = 0; e_stat = 0; e_rdata = 0;
    end else begin
      hit = (m_slot == 3) && (req_addr == m_addr) && (req_cmd == m_cmd) && (req_be == m_be);
      if (m_phase == 0) begin
        if (req_valid) begin
          if (m_slot == 0) take = 1;
          if (hit) begin
            give = 1; e_done = 1; e_stat = m_sstat; e_rdata = m_sdata; m_phase = 2;
          end else if (cfg_delay_retry) begin
            m_cnt = 16; m_phase = 1;
          end else begin
            e_retry = 1; m_phase = 2;
          end
        end
      end else if (m_phase == 1) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 1) begin e_retry = 1; m_phase = 2; end
      end else if (m_phase == 2) begin
        e_retry = 0; e_done = 0; e_stat = 0; e_rdata = 0; m_phase = 3;
      end else if (!req_valid) m_phase = 0;

      if (m_slot == 0 && take) begin
        m_slot = 1; m_addr = req_addr; m_cmd = req_cmd; m_be = req_be; m_wd = req_wdata;
        fwd_count++;
      end else if (m_slot == 1 && dst_req_ready) m_slot = 2;
      else if (m_slot == 2 && dst_rsp_valid) begin
        m_slot = 3; m_sstat = dst_rsp_status; m_sdata = m_cmd[0] ? 32'd0 : dst_rsp_rdata;
      end else if (m_slot == 3 && give) begin
        m_slot = 0; m_addr = 0; m_cmd = 0; m_be = 0; m_wd = 0; m_sstat = 0; m_sdata = 0;
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      chk({cur_tag, " outputs"},
          {26'd0, rsp_retry, rsp_done, rsp_status, rsp_rdata, dst_req_valid, 1'b0},
          {26'd0, e_retry, e_done, e_stat, e_rdata, (m_slot == 1), 1'b0});
      if (m_slot == 1)
        chk({cur_tag, " forward fields"},
            {dst_req_addr, dst_req_wdata ^ {dst_req_cmd, dst_req_be, 24'd0}},
            {m_addr, m_wd ^ {m_cmd, m_be, 24'd0}});
    end
  end

  // watchdog
  integer cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  bit          got_done;
  integer      lat;
  logic [1:0]  got_stat;
  logic [31:0] got_data;

  task automatic issue(input logic [31:0] a, input logic [3:0] c, input logic [3:0] b,
                       input logic [31:0] w);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_cmd = c; req_be = b; req_wdata = w;
    lat = 0;
    forever begin
      @(posedge clk); #5; lat++;
      if (rsp_retry || rsp_done || lat > 100) break;
    end
    got_done = rsp_done; got_stat = rsp_status; got_data = rsp_rdata;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic dst_accept();
    integer k;
    k = 0;
    while (!dst_req_valid && k < 50) begin @(posedge clk); #5; k++; end
    @(negedge clk); dst_req_ready = 1;
    @(negedge clk); dst_req_ready = 0;
  endtask

  task automatic dst_reply(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); dst_rsp_valid = 1; dst_rsp_status = s; dst_rsp_rdata = d;
    @(negedge clk); dst_rsp_valid = 0; dst_rsp_status = 0; dst_rsp_rdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  integer fwd_snap;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #5;
    cur_tag = "R1";
    chk("R1 reset idle", {rsp_retry, rsp_done, dst_req_valid}, 3'b000);

    // write transaction, immediate retry mode
    cur_tag = "R2";
    issue(32'h1000_0040, 4'b0111, 4'b1111, 32'hDEAD_BEEF);
    chk("R2 first request retried", {got_done, lat[7:0]}, {1'b0, 8'd1});
    chk("R8 immediate latency", lat, 1);
    cur_tag = "R7";
    issue(32'h1000_0040, 4'b0111, 4'b1111, 32'hDEAD_BEEF);
    chk("R7 match before forward accepted", got_done, 1'b0);
    cur_tag = "R3";
    dst_accept();
    cur_tag = "R7";
    issue(32'h1000_0040, 4'b0111, 4'b1111, 32'hDEAD_BEEF);
    chk("R7 match while waiting", got_done, 1'b0);
    cur_tag = "R13";
    dst_reply(2'b01, 32'h5555_AAAA);
    fwd_snap = fwd_count;
    cur_tag = "R6";
    issue(32'h1000_0044, 4'b0111, 4'b1111, 32'hDEAD_BEEF);
    chk("R6 address differs", got_done, 1'b0);
    issue(32'h1000_0040, 4'b0111, 4'b0011, 32'hDEAD_BEEF);
    chk("R6 byte enables differ", got_done, 1'b0);
    issue(32'h1000_0040, 4'b0110, 4'b1111, 32'hDEAD_BEEF);
    chk("R6 command differs", got_done, 1'b0);
    chk("R10 no forward while busy", fwd_count, fwd_snap);
    cur_tag = "R4";
    issue(32'h1000_0040, 4'b0111, 4'b1111, 32'h0);
    chk("R4 write completes", got_done, 1'b1);
    chk("R13 target abort passed", got_stat, 2'b01);
    chk("R4 write rdata zero", got_data, 32'h0);

    // read transaction
    cur_tag = "R5";
    issue(32'h2000_0100, 4'b0110, 4'b0101, 32'h0);
    chk("R11 next request captured", {got_done, dst_req_valid}, 2'b01);
    dst_accept();
    dst_reply(2'b00, 32'hCAFE_1234);
    issue(32'h2000_0100, 4'b0110, 4'b0101, 32'h0);
    chk("R5 read completes", got_done, 1'b1);
    chk("R5 read data", got_data, 32'hCAFE_1234);
    chk("R13 normal status", got_stat, 2'b00);

    // master abort on a read, then reset in mid-transaction
    cur_tag = "R13";
    issue(32'h3000_0000, 4'b0010, 4'b1000, 32'h0);
    dst_accept();
    dst_reply(2'b10, 32'h0BAD_0BAD);
    cur_tag = "R12";
    do_reset();
    issue(32'h3000_0000, 4'b0010, 4'b1000, 32'h0);
    chk("R12 stale result discarded", got_done, 1'b0);
    chk("R12 recaptured after reset", dst_req_valid, 1'b1);
    dst_accept();
    dst_reply(2'b10, 32'h0BAD_0BAD);
    cur_tag = "R13";
    issue(32'h3000_0000, 4'b0010, 4'b1000, 32'h0);
    chk("R13 master abort passed", {got_done, got_stat}, {1'b1, 2'b10});
    chk("R5 read data with abort", got_data, 32'h0BAD_0BAD);

    // delayed retry mode
    cur_tag = "R9";
    @(negedge clk); cfg_delay_retry = 1;
    issue(32'h4000_0008, 4'b0111, 4'b0001, 32'h1234_5678);
    chk("R9 delayed retry latency", {got_done, lat[7:0]}, {1'b0, 8'd16});
    dst_accept();
    issue(32'h4000_0008, 4'b0111, 4'b0001, 32'h1234_5678);
    chk("R9 delayed retry while busy", {got_done, lat[7:0]}, {1'b0, 8'd16});
    dst_reply(2'b00, 32'h0);
    issue(32'h4000_0008, 4'b0111, 4'b0001, 32'h1234_5678);
    chk("R9 completion not delayed", {got_done, lat[7:0]}, {1'b1, 8'd1});
    cur_tag = "R11";
    issue(32'h4000_0010, 4'b0110, 4'b1111, 32'h0);
    chk("R11 slot free after delivery", dst_req_valid, 1'b1);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule